// File: doc/BRIEF.md
# Event Interrupt Status Controller

This block collects event conditions from a serial-flash style controller (transmit and receive FIFO levels, a completion trigger) into one sticky status word. Software sees three 32-bit words on a simple strobe bus:
- a read-only status word;
- a read/write enable word;
- a write-only clear word.

The block drives one level-high interrupt line. An event condition that is high at a clock edge sets its status bit. A status bit stays set until software writes a 1 to the matching bit of the clear word.

If the condition is still high during the clearing cycle, the set wins and the bit reads back as 1. Software uses this to poll a FIFO state: it clears a bit, then reads it again.

Any access the block does not recognise raises a dedicated error bit in the same status word. This covers an unknown offset, a misaligned offset, or a write to the read-only status word.

Top module: `evtirq_top`

## Requirements
- R1: The word offsets are fixed: status at 0x30 (read-only), enable at 0x34 (read/write), clear at 0x38 (write-only; a read returns 0). A write to the enable word stores the written data, masked to the defined bits, at the next clock edge.
- R2: A defined condition input that is high at a clock edge sets its status bit at that edge. The bit stays set after the condition falls.
- R3: Writing 1 to a clear-word bit drops that status bit at the next edge when its condition is low. Clear-word bits written as 0 leave their status bits unchanged.
- R4: When a condition is high in the same cycle as a clear of its bit, the bit stays set. A clear-then-read of a persisting condition therefore reads 1.
- R5: After reset the status word and the enable word are 0 and the interrupt output is low.
- R6: The interrupt output is registered. It goes high one clock after some status bit and its enable bit are both 1, and it goes low one clock after no such pair remains.
- R7: Any of the following sets status bit 12 at the next edge: a read or write to an offset other than the three words, or a write to the status word. Such an access changes no other status bit and no enable bit.
- R8: Defined bits are: 12 error, 11 receive byte available, 9 all done, 8 receive full, 7 receive half full, 6 receive word available, 5 receive trigger, 3 transmit full, 2 transmit half full, 1 transmit empty, 0 transmit trigger. All other bits read 0 in status and enable. Condition inputs on undefined bits and on bit 12 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle while high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| hw_evt | input | 32 | Event condition levels, one per status bit position |
| irq | output | 1 | Level-high interrupt |

## Verification
Several properties are checked on every cycle:
- set status bits remain set unless a clear hits them;
- high conditions always land in status;
- cleared bits with a low condition drop;
- enable writes load the masked data;
- flagged bad accesses raise the error bit;
- the interrupt stays low while nothing is enabled.

Other behaviours only the bench scenarios can show. These are the exact bit positions seen through the bus, the clear-then-read polling idiom, and that a misaligned or unknown access leaves the enable word intact. The bench also shows the interrupt's one-cycle lag on both the rising and falling side.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;

    localparam int unsigned WORD_W = 32;

    // Status bit positions; software decodes these, so they are fixed
    localparam int unsigned B_ERR      = 12;
    localparam int unsigned B_RX_BYTE  = 11;
    localparam int unsigned B_DONE     = 9;
    localparam int unsigned B_RX_FULL  = 8;
    localparam int unsigned B_RX_HALF  = 7;
    localparam int unsigned B_RX_WORD  = 6;
    localparam int unsigned B_RX_TRIG  = 5;
    localparam int unsigned B_TX_FULL  = 3;
    localparam int unsigned B_TX_HALF  = 2;
    localparam int unsigned B_TX_EMPTY = 1;
    localparam int unsigned B_TX_TRIG  = 0;

    localparam logic [WORD_W-1:0] ERR_BIT = WORD_W'(1) << B_ERR;

    localparam logic [WORD_W-1:0] DEFINED_MASK =
        ERR_BIT |
        (WORD_W'(1) << B_RX_BYTE) | (WORD_W'(1) << B_DONE)    |
        (WORD_W'(1) << B_RX_FULL) | (WORD_W'(1) << B_RX_HALF) |
        (WORD_W'(1) << B_RX_WORD) | (WORD_W'(1) << B_RX_TRIG) |
        (WORD_W'(1) << B_TX_FULL) | (WORD_W'(1) << B_TX_HALF) |
        (WORD_W'(1) << B_TX_EMPTY) | (WORD_W'(1) << B_TX_TRIG);

    // Bits driven by external condition inputs
    localparam logic [WORD_W-1:0] HW_MASK = DEFINED_MASK & ~ERR_BIT;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'd0,
        HIT_STATUS = 2'd1,
        HIT_ENABLE = 2'd2,
        HIT_CLEAR  = 2'd3
    } word_hit_e;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] enable;
    } bank_t;

endpackage

// File: rtl/evtirq_decode.sv
module evtirq_decode
    import evtirq_pkg::*;
#(
    parameter int unsigned     ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h30,
    parameter logic [ADDR_W-1:0] ENABLE_OFS = 8'h34,
    parameter logic [ADDR_W-1:0] CLEAR_OFS  = 8'h38
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output word_hit_e         hit,
    output logic              enable_we,
    output logic              clear_we,
    output logic              illegal
);

    always_comb begin
        hit = HIT_NONE;
        if (addr == STATUS_OFS)      hit = HIT_STATUS;
        else if (addr == ENABLE_OFS) hit = HIT_ENABLE;
        else if (addr == CLEAR_OFS)  hit = HIT_CLEAR;

        enable_we = sel && wr && (hit == HIT_ENABLE);
        clear_we  = sel && wr && (hit == HIT_CLEAR);
        // Unknown offset, or a write to the read-only status word
        illegal   = sel && ((hit == HIT_NONE) || (wr && (hit == HIT_STATUS)));
    end

endmodule

// File: rtl/evtirq_bank.sv
module evtirq_bank
    import evtirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] hw_evt,
    input  logic              illegal,
    input  logic              enable_we,
    input  logic              clear_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] status_q,
    output logic [WORD_W-1:0] enable_q
);

    bank_t             bank_d, bank_q;
    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] clr_mask;

    // Per-bit set source: external condition, error flag, or tied off
    for (genvar i = 0; i < WORD_W; i++) begin : g_set
        if (i == B_ERR) begin : g_err
            assign set_vec[i] = illegal;
        end else if (HW_MASK[i]) begin : g_hw
            assign set_vec[i] = hw_evt[i];
        end else begin : g_none
            assign set_vec[i] = 1'b0;
        end
    end

    assign clr_mask = clear_we ? (wdata & DEFINED_MASK) : '0;

    always_comb begin
        bank_d        = bank_q;
        // A set in the same cycle wins over the clear
        bank_d.status = (bank_q.status & ~clr_mask) | set_vec;
        if (enable_we)
            bank_d.enable = wdata & DEFINED_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign status_q = bank_q.status;
    assign enable_q = bank_q.enable;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != '0) |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask))); // R2
    AST_COND_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_we |=> ((status_q & $past(clr_mask & ~set_vec)) == '0)); // R3
    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        enable_we |=> (enable_q == ($past(wdata) & DEFINED_MASK))); // R1
    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> status_q[B_ERR]); // R7
    AST_ERR_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(enable_q)); // R7

endmodule

// File: rtl/evtirq_out.sv
module evtirq_out
    import evtirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] status,
    input  logic [WORD_W-1:0] enable,
    output logic              irq
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = |(status & enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |=> !irq); // R6
    AST_IRQ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(status != '0)); // R6

endmodule

// File: rtl/evtirq_top.sv
module evtirq_top
    import evtirq_pkg::*;
#(
    parameter int unsigned     ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h30,
    parameter logic [ADDR_W-1:0] ENABLE_OFS = 8'h34,
    parameter logic [ADDR_W-1:0] CLEAR_OFS  = 8'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [WORD_W-1:0] hw_evt,
    output logic              irq
);

    word_hit_e         hit;
    logic              enable_we, clear_we, illegal;
    logic [WORD_W-1:0] status_q, enable_q;

    evtirq_decode #(
        .ADDR_W     (ADDR_W),
        .STATUS_OFS (STATUS_OFS),
        .ENABLE_OFS (ENABLE_OFS),
        .CLEAR_OFS  (CLEAR_OFS)
    ) u_decode (
        .sel       (bus_sel),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .hit       (hit),
        .enable_we (enable_we),
        .clear_we  (clear_we),
        .illegal   (illegal)
    );

    evtirq_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_evt    (hw_evt),
        .illegal   (illegal),
        .enable_we (enable_we),
        .clear_we  (clear_we),
        .wdata     (bus_wdata),
        .status_q  (status_q),
        .enable_q  (enable_q)
    );

    evtirq_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_q),
        .enable (enable_q),
        .irq    (irq)
    );

    // Read mux; the clear word and unknown offsets read as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (hit)
                HIT_STATUS: bus_rdata = status_q;
                HIT_ENABLE: bus_rdata = enable_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == CLEAR_OFS)) |-> (bus_rdata == '0)); // R1
    AST_UNDEF_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |-> ((bus_rdata & ~DEFINED_MASK) == '0)); // R8

endmodule

// File: tb/sim_evtirq_top.sv
`timescale 1ns/1ps
module sim_evtirq_top;

    localparam logic [7:0] A_STAT = 8'h30;
    localparam logic [7:0] A_EN   = 8'h34;
    localparam logic [7:0] A_CLR  = 8'h38;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, hw_evt = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    evtirq_top u0 (
        .clk (clk), .rst_n (rst_n),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .hw_evt (hw_evt), .irq (irq)
    );

    typedef struct packed {
        logic [31:0] evt;
        logic        sel;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0002, 1'b0, 1'b0, 8'h00, 32'h0,        32'h0000_0002}, // R2 set
        '{32'h0000_0000, 1'b0, 1'b0, 8'h00, 32'h0,        32'h0000_0002}, // R2 sticky
        '{32'h0000_0000, 1'b1, 1'b1, 8'h38, 32'h0,        32'h0000_0002}, // R3 zero clear
        '{32'h0000_0000, 1'b1, 1'b1, 8'h38, 32'h2,        32'h0000_0000}, // R3 clear
        '{32'h0000_0108, 1'b0, 1'b0, 8'h00, 32'h0,        32'h0000_0108}, // R2
        '{32'h0000_0100, 1'b1, 1'b1, 8'h38, 32'h108,      32'h0000_0100}, // R4 set wins
        '{32'h0000_0000, 1'b1, 1'b1, 8'h38, 32'hFFFF_FFFF, 32'h0000_0000}, // R3
        '{32'hFFFF_FFFF, 1'b0, 1'b0, 8'h00, 32'h0,        32'h0000_0BEF}, // R8
        '{32'h0000_0000, 1'b1, 1'b1, 8'h38, 32'hFFFF_FFFF, 32'h0000_0000}, // R3
        '{32'h0000_0000, 1'b1, 1'b1, 8'h30, 32'h0000_FFFF, 32'h0000_1000}, // R7 status write
        '{32'h0000_0000, 1'b1, 1'b1, 8'h38, 32'h1000,     32'h0000_0000}, // R3
        '{32'h0000_0000, 1'b1, 1'b0, 8'h3C, 32'h0,        32'h0000_1000}, // R7 unknown read
        '{32'h0000_0000, 1'b1, 1'b1, 8'h38, 32'h1000,     32'h0000_0000}, // R3
        '{32'h0000_0000, 1'b1, 1'b1, 8'h31, 32'h0,        32'h0000_1000}, // R7 misaligned
        '{32'h0000_0000, 1'b1, 1'b1, 8'h38, 32'h1000,     32'h0000_0000}  // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        go_idle();
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        go_idle();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        check("R5 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;

        do_read(A_STAT, rd); check("R5 status after reset", rd, 32'h0);
        do_read(A_EN, rd);   check("R5 enable after reset", rd, 32'h0);
        check("R5 irq after reset", {31'b0, irq}, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            hw_evt = VECS[i].evt; bus_sel = VECS[i].sel; bus_wr = VECS[i].wr;
            bus_addr = VECS[i].addr; bus_wdata = VECS[i].wdata;
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_STAT; bus_wdata = '0;
            #1 check($sformatf("vector %0d status", i), bus_rdata, VECS[i].exp);
            go_idle();
        end
        hw_evt = '0;

        // R1 / R8: enable masked, clear word reads zero
        do_write(A_EN, 32'hFFFF_FFFF);
        do_read(A_EN, rd);  check("R1 R8 enable readback", rd, 32'h0000_1BEF);
        do_read(A_CLR, rd); check("R1 clear reads zero", rd, 32'h0);

        // R7: unknown-offset write leaves enable alone, flags error
        do_write(8'h40, 32'h0);
        do_read(A_EN, rd);   check("R7 enable kept", rd, 32'h0000_1BEF);
        do_read(A_STAT, rd); check("R7 error flag", rd, 32'h0000_1000);
        do_write(A_CLR, 32'h1000);

        // R6: interrupt timing, rise and fall
        do_write(A_EN, 32'h2);
        @(negedge clk); hw_evt = 32'h2;
        @(negedge clk); #1 check("R6 irq lags status", {31'b0, irq}, 32'h0);
        hw_evt = '0;
        @(negedge clk); #1 check("R6 irq high", {31'b0, irq}, 32'h1);
        do_write(A_CLR, 32'h2);
        #1 check("R6 irq still high after clear edge", {31'b0, irq}, 32'h1);
        @(negedge clk); #1 check("R6 irq low", {31'b0, irq}, 32'h0);

        // R6: status without matching enable gives no interrupt
        do_write(A_EN, 32'h1);
        @(negedge clk); hw_evt = 32'h2;
        @(negedge clk); hw_evt = '0;
        repeat (2) @(negedge clk);
        #1 check("R6 unmatched enable", {31'b0, irq}, 32'h0);
        do_read(A_STAT, rd); check("R6 status set", rd, 32'h2);
        do_write(A_CLR, 32'h2);

        // R4: polling idiom with persisting condition
        @(negedge clk); hw_evt = 32'h80;
        @(negedge clk);
        do_write(A_CLR, 32'h80);
        do_read(A_STAT, rd); check("R4 poll reads one", rd, 32'h80);
        hw_evt = '0;
        do_write(A_CLR, 32'h80);
        do_read(A_STAT, rd); check("R3 drop after condition falls", rd, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule